// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block turns a 7-bit register offset taken from an instruction, together with two bank-select bits, into one physical data access for a small microcontroller. Every access is sorted into one of four regions. The low offsets go to a special-function-register file outside the block. The middle offsets go to general-purpose RAM that is private to each bank. A 16-byte window at the top is shared by banks 0 and 1. Any access through the two unimplemented banks goes nowhere.

The general-purpose RAM sits inside the block. Reads from it are combinational, and writes to it commit on the rising clock edge. The special-function-register file is reached through a plain strobe, address, bank and data port. A parameter mask picks which special-function offsets seen through bank 1 are redirected to their bank-0 copies. Frequently used registers can then be reached without switching banks.

Top module: `dbm_top`

## Requirements
- R1: With bank-select `00` or `01` and offset `00h`–`1Fh`, `sfr_sel` is 1. In that case `sfr_addr` equals the offset's low 5 bits, `sfr_bank` equals bank-select bit 0 (when R2 does not apply), and `rd_data` equals `sfr_rd_data`.
- R2: With bank-select `01` and a special-function offset whose bit is set in `MIRROR_MASK` (bit n covers offset n), `sfr_bank` is 0, so the bank-0 register is reached.
- R3: Offsets `20h`–`6Fh` are private to each bank. A write through bank 0 is not visible at the same offset through bank 1, and a write through bank 1 is not visible through bank 0.
- R4: Offsets `70h`–`7Fh` are one shared 16-byte window. A byte written through bank 0 or bank 1 is read back through either bank.
- R5: When bank-select bit 1 is 1 (banks 2 and 3), `rd_data` is `00h`, `sfr_sel` and `sfr_wr_en` are 0, and a write changes no RAM byte.
- R6: A general-purpose read is combinational. In the cycle that carries a write, `rd_data` still shows the old byte. The new byte is visible from the next cycle on.
- R7: After reset, every general-purpose byte reads `00h`.
- R8: `sfr_wr_en` is `wr_en` during a special-function access, and `sfr_wr_data` equals `wr_data`. A special-function access never writes general-purpose RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the RAM |
| bank_sel | input | 2 | Bank-select bits (bit 1 high = unimplemented bank) |
| reg_addr | input | 7 | Register offset within the bank |
| wr_en | input | 1 | Write request for the current access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| sfr_sel | output | 1 | Access targets the special-function file |
| sfr_addr | output | 5 | Special-function offset |
| sfr_bank | output | 1 | Special-function bank after mirroring |
| sfr_wr_en | output | 1 | Write strobe toward the special-function file |
| sfr_wr_data | output | 8 | Write data toward the special-function file |
| sfr_rd_data | input | 8 | Read data returned by the special-function file |

## Verification
A general-purpose write and a combinational read of the same byte always fall in one cycle. That cycle must show the old byte, and the next cycle must show the new one. Random accesses land on recently written bytes often enough to provoke this, and a byte model in the bench is updated only after the edge and judges both sides. A second collision comes from writes through an unimplemented bank or into the shared window whose offsets match bytes that hold live data. Each such write is followed by a read-back through the other bank, which must show the shared byte or the untouched one.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_SFR    = 2'd1,
    RGN_PRIV   = 2'd2,
    RGN_SHARED = 2'd3
  } region_e;

  // Sort one access by bank and offset.
  function automatic region_e classify(input logic bank_hi, input int off,
                                       input int sfr_span, input int bank_span,
                                       input int shared_span);
    region_e r;
    if (bank_hi)
      r = RGN_NONE;
    else if (off < sfr_span)
      r = RGN_SFR;
    else if (off >= bank_span - shared_span)
      r = RGN_SHARED;
    else
      r = RGN_PRIV;
    return r;
  endfunction

  // Physical RAM row: bank0 private, bank1 private, then the shared window.
  function automatic int phys_row(input logic bank_lo, input region_e r, input int off,
                                  input int sfr_span, input int bank_span,
                                  input int shared_span);
    int priv_span;
    int row;
    priv_span = bank_span - sfr_span - shared_span;
    case (r)
      RGN_PRIV:   row = (bank_lo ? priv_span : 0) + (off - sfr_span);
      RGN_SHARED: row = 2 * priv_span + (off - (bank_span - shared_span));
      default:    row = 0;
    endcase
    return row;
  endfunction

endpackage

// File: rtl/dbm_decode.sv
module dbm_decode
  import dbm_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SFR_SPAN    = 32,
  parameter int SHARED_SPAN = 16,
  parameter logic [SFR_SPAN-1:0] MIRROR_MASK = '0,
  parameter int IDX_W       = 8,
  parameter int SFR_W       = 5
) (
  input  logic [1:0]        bank_sel,
  input  logic [ADDR_W-1:0] reg_addr,
  output region_e           region,
  output logic [IDX_W-1:0]  ram_idx,
  output logic              sfr_sel,
  output logic              sfr_bank,
  output logic [SFR_W-1:0]  sfr_addr
);
  localparam int BANK_SPAN = 1 << ADDR_W;

  logic mirrored;

  always_comb begin
    region   = classify(bank_sel[1], int'(reg_addr), SFR_SPAN, BANK_SPAN, SHARED_SPAN);
    ram_idx  = IDX_W'(phys_row(bank_sel[0], region, int'(reg_addr),
                               SFR_SPAN, BANK_SPAN, SHARED_SPAN));
    sfr_sel  = (region == RGN_SFR);
    sfr_addr = reg_addr[SFR_W-1:0];
    mirrored = MIRROR_MASK[reg_addr[SFR_W-1:0]];
    sfr_bank = bank_sel[0] & ~mirrored;
  end

endmodule

// File: rtl/dbm_gpr_ram.sv
module dbm_gpr_ram #(
  parameter int DEPTH  = 176,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[idx] <= wdata;
    end
  end

  assign rdata = cells[idx];

endmodule

// File: rtl/dbm_read_mux.sv
module dbm_read_mux
  import dbm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  region_e           region,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] sfr_rdata,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    unique case (region)
      RGN_PRIV, RGN_SHARED: rd_data = ram_rdata;
      RGN_SFR:              rd_data = sfr_rdata;
      default:              rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dbm_top.sv
module dbm_top
  import dbm_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SFR_SPAN    = 32,
  parameter int SHARED_SPAN = 16,
  parameter logic [SFR_SPAN-1:0] MIRROR_MASK = 32'h0000_008B,
  parameter int SFR_W       = $clog2(SFR_SPAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bank_sel,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              sfr_sel,
  output logic [SFR_W-1:0]  sfr_addr,
  output logic              sfr_bank,
  output logic              sfr_wr_en,
  output logic [DATA_W-1:0] sfr_wr_data,
  input  logic [DATA_W-1:0] sfr_rd_data
);
  localparam int BANK_SPAN = 1 << ADDR_W;
  localparam int PRIV_SPAN = BANK_SPAN - SFR_SPAN - SHARED_SPAN;
  localparam int RAM_DEPTH = 2 * PRIV_SPAN + SHARED_SPAN;
  localparam int IDX_W     = $clog2(RAM_DEPTH);

  region_e           region;
  logic [IDX_W-1:0]  ram_idx;
  logic [DATA_W-1:0] ram_rdata;
  logic              gpr_hit;
  logic              ram_we;

  dbm_decode #(
    .ADDR_W(ADDR_W), .SFR_SPAN(SFR_SPAN), .SHARED_SPAN(SHARED_SPAN),
    .MIRROR_MASK(MIRROR_MASK), .IDX_W(IDX_W), .SFR_W(SFR_W)
  ) decode_i (
    .bank_sel(bank_sel), .reg_addr(reg_addr), .region(region),
    .ram_idx(ram_idx), .sfr_sel(sfr_sel), .sfr_bank(sfr_bank), .sfr_addr(sfr_addr)
  );

  assign gpr_hit     = (region == RGN_PRIV) || (region == RGN_SHARED);
  assign ram_we      = wr_en & gpr_hit;
  assign sfr_wr_en   = wr_en & sfr_sel;
  assign sfr_wr_data = wr_data;

  dbm_gpr_ram #(.DEPTH(RAM_DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) ram_i (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(ram_idx),
    .wdata(wr_data), .rdata(ram_rdata)
  );

  dbm_read_mux #(.DATA_W(DATA_W)) mux_i (
    .region(region), .ram_rdata(ram_rdata), .sfr_rdata(sfr_rd_data), .rd_data(rd_data)
  );

endmodule

// File: rtl/dbm_checker.sv
module dbm_checker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SFR_SPAN = 32,
  parameter int SHARED_SPAN = 16,
  parameter logic [SFR_SPAN-1:0] MIRROR_MASK = '0,
  parameter int SFR_W = 5,
  parameter int IDX_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bank_sel,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              sfr_sel,
  input logic [SFR_W-1:0]  sfr_addr,
  input logic              sfr_bank,
  input logic              sfr_wr_en,
  input logic              ram_we,
  input logic              gpr_hit,
  input logic [IDX_W-1:0]  ram_idx
);
  localparam int SHARED_LO = (1 << ADDR_W) - SHARED_SPAN;
  localparam int SHARED_ROW = 2 * (SHARED_LO - SFR_SPAN);

  assert_unimpl_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel[1] |-> (rd_data == '0 && !sfr_sel && !sfr_wr_en && !ram_we));

  assert_sfr_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_sel[1] && int'(reg_addr) < SFR_SPAN) |-> (sfr_sel && sfr_addr == reg_addr[SFR_W-1:0]));

  assert_mirror_bank0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel == 2'b01 && sfr_sel && MIRROR_MASK[reg_addr[SFR_W-1:0]]) |-> !sfr_bank);

  assert_shared_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_sel[1] && int'(reg_addr) >= SHARED_LO) |-> (gpr_hit && int'(ram_idx) >= SHARED_ROW));

  assert_sfr_no_ram_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> (!ram_we && sfr_wr_en == wr_en));

  assert_write_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ram_we) && gpr_hit && ram_idx == $past(ram_idx))
      |-> rd_data == $past(wr_data));
endmodule

bind dbm_top dbm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SFR_SPAN(SFR_SPAN), .SHARED_SPAN(SHARED_SPAN),
  .MIRROR_MASK(MIRROR_MASK), .SFR_W(SFR_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .reg_addr(reg_addr), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .sfr_sel(sfr_sel), .sfr_addr(sfr_addr),
  .sfr_bank(sfr_bank), .sfr_wr_en(sfr_wr_en), .ram_we(ram_we), .gpr_hit(gpr_hit),
  .ram_idx(ram_idx)
);

// File: tb/dbm_top_tb.sv
module dbm_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h0000_008B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bank_sel = 2'b00;
  logic [6:0] reg_addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sfr_sel;
  logic [4:0] sfr_addr;
  logic       sfr_bank;
  logic       sfr_wr_en;
  logic [7:0] sfr_wr_data;
  logic [7:0] sfr_rd_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] model [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] sfr_model(input logic b, input logic [4:0] a);
    return {b, 2'b10, a} ^ 8'h3C;
  endfunction

  assign sfr_rd_data = sfr_model(sfr_bank, sfr_addr);

  dbm_top #(.MIRROR_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sfr_sel(sfr_sel),
    .sfr_addr(sfr_addr), .sfr_bank(sfr_bank), .sfr_wr_en(sfr_wr_en),
    .sfr_wr_data(sfr_wr_data), .sfr_rd_data(sfr_rd_data)
  );

  // Bench key: shared window folds both banks to one slot.
  function automatic int key_of(input logic [1:0] b, input logic [6:0] off);
    if (off >= 7'h70) return 256 + int'(off);
    return int'(b[0]) * 128 + int'(off);
  endfunction

  function automatic logic exp_bank(input logic [1:0] b, input logic [6:0] off);
    return b[0] && !MASK[off[4:0]];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] b, input logic [6:0] off,
                        input logic we, input logic [7:0] d);
    logic [7:0] exp_rd;
    logic unimpl;
    logic is_sfr;
    @(negedge clk);
    bank_sel = b; reg_addr = off; wr_en = we; wr_data = d;
    #1;
    unimpl = b[1];
    is_sfr = !unimpl && off < 7'h20;
    if (unimpl) begin
      check("R5 rd", rd_data, 8'h00);
      check("R5 sel", {sfr_sel, sfr_wr_en}, 2'b00);
    end else if (is_sfr) begin
      exp_rd = sfr_model(exp_bank(b, off), off[4:0]);
      check("R1 sel", sfr_sel, 1'b1);
      check("R1 addr", sfr_addr, off[4:0]);
      check((b[0] && MASK[off[4:0]]) ? "R2 bank" : "R1 bank", sfr_bank, exp_bank(b, off));
      check("R1 rd", rd_data, exp_rd);
      check("R8 wr", {sfr_wr_en, sfr_wr_data}, {we, d});
    end else begin
      check("R8 nosel", sfr_sel, 1'b0);
      check(we ? "R6 old" : (off >= 7'h70 ? "R4 rd" : "R3 rd"),
            rd_data, model[key_of(b, off)]);
    end
    @(posedge clk);
    if (we && !unimpl && !is_sfr) model[key_of(b, off)] = d;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R7: cleared after reset
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); bank_sel = 2'(k % 2); reg_addr = 7'h20 + 7'(k * 27); wr_en = 1'b0;
      #1 check("R7 clear", rd_data, 8'h00);
    end
    @(negedge clk); bank_sel = 2'b01; reg_addr = 7'h7F; #1 check("R7 clear", rd_data, 8'h00);

    // R4: shared window both directions
    access(2'b00, 7'h75, 1'b1, 8'hA1);
    access(2'b01, 7'h75, 1'b0, 8'h00);
    check("R4 alias", rd_data, 8'hA1);
    access(2'b01, 7'h70, 1'b1, 8'h5E);
    access(2'b00, 7'h70, 1'b0, 8'h00);
    check("R4 alias", rd_data, 8'h5E);
    // R3: private bytes stay apart
    access(2'b00, 7'h40, 1'b1, 8'h77);
    access(2'b01, 7'h40, 1'b0, 8'h00);
    check("R3 private", rd_data, 8'h00);
    access(2'b01, 7'h6F, 1'b1, 8'h19);
    access(2'b00, 7'h6F, 1'b0, 8'h00);
    check("R3 private", rd_data, 8'h00);
    // R6: write then same-byte read
    access(2'b00, 7'h40, 1'b1, 8'hC4);
    access(2'b00, 7'h40, 1'b0, 8'h00);
    check("R6 new", rd_data, 8'hC4);
    // R5: unimplemented banks leave live bytes alone
    access(2'b10, 7'h70, 1'b1, 8'hEE);
    access(2'b11, 7'h40, 1'b1, 8'hEE);
    access(2'b00, 7'h70, 1'b0, 8'h00);
    check("R5 untouched", rd_data, 8'h5E);
    access(2'b01, 7'h40, 1'b0, 8'h00);
    check("R5 untouched", rd_data, 8'h00);
    // R2 / R1: mirrored and plain SFR offsets in bank 1
    access(2'b01, 7'h03, 1'b1, 8'h42);
    check("R2 mirror", sfr_bank, 1'b0);
    access(2'b01, 7'h02, 1'b0, 8'h00);
    check("R1 plain", sfr_bank, 1'b1);
    access(2'b01, 7'h1F, 1'b1, 8'h11);

    // Random mix, small address set to force collisions
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] b;
      logic [6:0] off;
      int r;
      r = int'($urandom_range(0, 9));
      b = (r == 0) ? 2'b10 : (r == 1) ? 2'b11 : 2'(r % 2);
      r = int'($urandom_range(0, 3));
      case (r)
        0: off = 7'($urandom_range(0, 31));
        1: off = 7'($urandom_range(32, 39));
        2: off = 7'($urandom_range(104, 115));
        default: off = 7'($urandom_range(0, 127));
      endcase
      access(b, off, 1'($urandom_range(0, 1)), 8'($urandom));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule